// File: doc/BRIEF.md
# Hysteretic Step-Down Gate Controller

This block is the digital gate sequencer for a synchronous step-down power stage. Three analog comparator flags feed it: an output-below-target flag, a high-side over-current flag and an inductor near-zero-current flag. From these it produces the enable for the high-side switch and the enable for the low-side rectifier switch. A switching pulse starts only when the output is low. Minimum on and off dwell times, counted in clock cycles, bound the pulse rate. A one-cycle gap with both switches off separates every hand-over between the two switches.

The comparator flags each pass through a two-flop synchroniser before the sequencer uses them. The over-current flag also gates the high-side enable directly, so an over-current event removes drive without waiting for the synchroniser. When the enable input is low, both switches are held off, which leaves the switching node floating. The dwell times and the synchroniser depth are parameters. The defaults of 11 and 10 cycles suit a 100 MHz clock.

Top module: `hbuck_gate_ctl`

## Requirements
- R1: While `rst_n` is low, both `hs_gate_o` and `ls_gate_o` are 0, asynchronously and at once.
- R2: A high-side pulse starts only after the synchronised `below_reg_i` is seen high. With a 2-stage synchroniser and the off dwell satisfied, if the raw flag is first sampled high at clock edge P0, `hs_gate_o` rises at edge P3.
- R3: Once on, the high side stays on for at least `T_ON_CYC` cycles. After that it stays on until the synchronised below flag clears. If `below_reg_i` is held for B sampled edges starting at P0, the pulse lasts max(`T_ON_CYC`, B-1) cycles. Over-current and disable are the only exceptions.
- R4: `hs_ilim_i` high forces `hs_gate_o` low in the same cycle, through a combinational path. The pulse then ends within the synchroniser latency plus one cycle, and drive does not return when the flag falls.
- R5: Between two high-side pulses, the high side stays off for at least `T_OFF_CYC`+2 cycles. If the below flag stays high, the next pulse starts exactly then. After a current-limit cut at raw edge L, the port shows `T_OFF_CYC`+5 low samples.
- R6: The low side turns on one cycle after the high side turns off. It turns off three cycles after `ls_izero_i` is first set high, where the cycle in which the low side first shows high counts as the first of those three.
- R7: The low side is off for at least one full cycle before the high side turns on. If no zero-current event occurs, the low side stays on for exactly `T_OFF_CYC` cycles.
- R8: The high side is off for at least one full cycle before the low side turns on. The two enables are never high together.
- R9: With `enable_i` low, both enables are 0 from the next clock edge, and no pulse starts. After `enable_i` returns high, following a long idle time with the below flag set, the high side turns on on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable, active high |
| below_reg_i | input | 1 | Comparator: output is below its target |
| hs_ilim_i | input | 1 | Comparator: high-side current above limit |
| ls_izero_i | input | 1 | Comparator: inductor current below rectifier-off level |
| hs_gate_o | output | 1 | High-side switch enable |
| ls_gate_o | output | 1 | Low-side switch enable |

## Verification
On every cycle, the embedded properties check several things. Both hand-over gaps hold. The measured on and off run lengths respect their floors. A pulse never begins without a prior below indication. Synchronised over-current and zero-current events end their phases on the next edge. Disable clears both outputs. The bench scenarios show what the properties cannot: the exact pulse and rectifier widths for a range of flag hold times, the same-cycle combinational cut on over-current, the exact restart spacing, and the absence of pulses while disabled.

// File: rtl/hbuck_pkg.sv
package hbuck_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_GAP_HI = 3'd1,
      PH_HIGH   = 3'd2,
      PH_GAP_LO = 3'd3,
      PH_LOW    = 3'd4
   } phase_t;

   localparam int FLAG_BELOW = 0;
   localparam int FLAG_ILIM  = 1;
   localparam int FLAG_ZERO  = 2;
   localparam int FLAG_COUNT = 3;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("flag_sync: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[DEPTH-2:0], d};
   end

   assign q = chain[DEPTH-1];

endmodule

// File: rtl/dwell_counter.sv
module dwell_counter #(
   parameter int W   = 4,
   parameter int MAX = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] count
);

   if (MAX >= (1 << W)) begin : g_bad_width
      $error("dwell_counter: MAX does not fit in W bits");
   end

   localparam logic [W-1:0] CAP = W'(MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (restart)      count <= '0;
      else if (count != CAP) count <= count + 1'b1;
   end

endmodule

// File: rtl/hbuck_gate_ctl.sv
module hbuck_gate_ctl
   import hbuck_pkg::*;
#(
   parameter int T_ON_CYC   = 11,
   parameter int T_OFF_CYC  = 10,
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic below_reg_i,
   input  logic hs_ilim_i,
   input  logic ls_izero_i,
   output logic hs_gate_o,
   output logic ls_gate_o
);

   localparam int CNT_MAX = (T_ON_CYC > T_OFF_CYC) ? T_ON_CYC : T_OFF_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int RUN_W   = $clog2(CNT_MAX + 8) + 1;

   if (T_ON_CYC < 1) begin : g_bad_on
      $error("hbuck_gate_ctl: T_ON_CYC must be at least 1");
   end
   if (T_OFF_CYC < 1) begin : g_bad_off
      $error("hbuck_gate_ctl: T_OFF_CYC must be at least 1");
   end

   // comparator synchronisers
   logic [FLAG_COUNT-1:0] flag_raw, flag_s;
   assign flag_raw[FLAG_BELOW] = below_reg_i;
   assign flag_raw[FLAG_ILIM]  = hs_ilim_i;
   assign flag_raw[FLAG_ZERO]  = ls_izero_i;

   for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_sync
      flag_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (flag_raw[g]),
         .q     (flag_s[g])
      );
   end

   logic below_s, ilim_s, zero_s;
   assign below_s = flag_s[FLAG_BELOW];
   assign ilim_s  = flag_s[FLAG_ILIM];
   assign zero_s  = flag_s[FLAG_ZERO];

   // phase sequencer
   phase_t           phase_q, phase_nx;
   logic [CNT_W-1:0] dwell;
   logic             on_done, off_done, idle_done;

   assign on_done   = dwell >= CNT_W'(T_ON_CYC - 1);
   assign off_done  = dwell >= CNT_W'(T_OFF_CYC - 1);
   assign idle_done = dwell >= CNT_W'(T_OFF_CYC);

   always_comb begin
      phase_nx = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (enable_i && below_s && idle_done) phase_nx = PH_GAP_HI;
         PH_GAP_HI: phase_nx = enable_i ? PH_HIGH : PH_IDLE;
         PH_HIGH: begin
            if (!enable_i)                           phase_nx = PH_IDLE;
            else if (ilim_s || (on_done && !below_s)) phase_nx = PH_GAP_LO;
         end
         PH_GAP_LO: phase_nx = enable_i ? PH_LOW : PH_IDLE;
         PH_LOW: begin
            if (!enable_i)                 phase_nx = PH_IDLE;
            else if (off_done && below_s)  phase_nx = PH_GAP_HI;
         end
         default:   phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_nx;
   end

   dwell_counter #(.W(CNT_W), .MAX(CNT_MAX)) u_dwell (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (phase_nx != phase_q),
      .count   (dwell)
   );

   // rectifier release on zero current
   logic ls_done;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ls_done <= 1'b0;
      else if (phase_q != PH_LOW) ls_done <= 1'b0;
      else if (zero_s)            ls_done <= 1'b1;
   end

   logic hs_q, ls_q;
   assign hs_q      = (phase_q == PH_HIGH);
   assign ls_q      = (phase_q == PH_LOW) && !ls_done;
   assign hs_gate_o = hs_q && !hs_ilim_i;
   assign ls_gate_o = ls_q;

   // run-length monitors feeding the dwell properties
   logic [RUN_W-1:0] on_run, off_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_run  <= '0;
         off_run <= '0;
      end else begin
         if (!hs_q)             on_run <= '0;
         else if (~&on_run)     on_run <= on_run + 1'b1;
         if (hs_q)              off_run <= '0;
         else if (~&off_run)    off_run <= off_run + 1'b1;
      end
   end

   a_r2_start_needs_below: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_q) |-> $past(below_s, 2));
   a_r3_min_on: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hs_q) && $past(enable_i) && !$past(ilim_s)) |-> (on_run >= RUN_W'(T_ON_CYC)));
   a_r4_ilim_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q && ilim_s) |=> !hs_q);
   a_r5_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_q) |-> (off_run >= RUN_W'(T_OFF_CYC + 2)));
   a_r6_zero_releases_ls: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_q && zero_s) |=> !ls_q);
   a_r7_ls_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_q) |-> !$past(ls_q));
   a_r8_hs_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_q) |-> !$past(hs_q));
   a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!hs_gate_o && !ls_gate_o));

endmodule

// File: tb/tb_hbuck_gate_ctl.sv
module tb_hbuck_gate_ctl;

   localparam int TON  = 11;
   localparam int TOFF = 10;
   // stimulus rows: {cycles below_reg held, cycles after ls rise before zero flag}
   localparam int NROW = 4;
   localparam int VEC [NROW][2] = '{'{3, 0}, '{12, 2}, '{13, 5}, '{20, 1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b1, below = 1'b0, ilim = 1'b0, izero = 1'b0;
   logic hs, ls;

   int checks = 0, fails = 0;
   int hs_run = 0, ls_run = 0, hs_low = 0;
   int last_hs = 0, last_ls = 0, last_hs_low = 0, hs_pulses = 0, overlap = 0;

   always #10 clk = ~clk;

   hbuck_gate_ctl #(.T_ON_CYC(TON), .T_OFF_CYC(TOFF), .SYNC_DEPTH(2)) dut (
      .clk(clk), .rst_n(rst_n), .enable_i(en), .below_reg_i(below),
      .hs_ilim_i(ilim), .ls_izero_i(izero), .hs_gate_o(hs), .ls_gate_o(ls));

   always @(negedge clk) begin
      if (hs && ls) overlap++;
      if (hs) begin
         hs_run++;
         if (hs_low != 0) begin last_hs_low = hs_low; hs_low = 0; end
      end else begin
         hs_low++;
         if (hs_run != 0) begin last_hs = hs_run; hs_run = 0; hs_pulses++; end
      end
      if (ls) ls_run++;
      else if (ls_run != 0) begin last_ls = ls_run; ls_run = 0; end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic wait_hs(output int ok);
      ok = 0;
      for (int i = 0; i < 60; i++) begin
         step(1);
         if (hs) begin ok = 1; break; end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
   end

   initial begin
      int ok, pulses_before, exp_hs;
      // R1: reset state
      step(3);
      check(hs == 1'b0, "R1 hs in reset", hs, 0);
      check(ls == 1'b0, "R1 ls in reset", ls, 0);
      rst_n = 1'b1;
      step(20);

      // R2, R3, R6: table of below hold lengths and zero-flag delays
      for (int r = 0; r < NROW; r++) begin
         below = 1'b1;
         step(VEC[r][0]);
         below = 1'b0;
         ok = 0;
         for (int i = 0; i < 60; i++) begin
            step(1);
            if (ls) begin ok = 1; break; end
         end
         check(ok == 1, "R6 ls turns on after pulse", ok, 1);
         step(VEC[r][1]);
         izero = 1'b1;
         step(20);
         exp_hs = (TON > VEC[r][0] - 1) ? TON : VEC[r][0] - 1;
         check(last_hs == exp_hs, "R3 hs pulse width", last_hs, exp_hs);
         check(last_ls == 3 + VEC[r][1], "R6 ls width to zero flag", last_ls, 3 + VEC[r][1]);
         izero = 1'b0;
         step(20);
      end

      // R4, R5, R7: current limit with output still low
      below = 1'b1;
      wait_hs(ok);
      check(ok == 1, "R2 hs starts on below", ok, 1);
      step(2);
      ilim = 1'b1;
      #1 check(hs == 1'b0, "R4 combinational cut", hs, 0);
      step(4);
      ilim = 1'b0;
      #1 check(hs == 1'b0, "R4 no resume after limit", hs, 0);
      check(last_hs == 2, "R4 cut pulse width", last_hs, 2);
      wait_hs(ok);
      @(negedge clk); #1;
      check(last_hs_low == TOFF + 5, "R5 off spacing", last_hs_low, TOFF + 5);
      check(last_ls == TOFF, "R7 ls width without zero flag", last_ls, TOFF);
      below = 1'b0;
      step(40);

      // R9: disable during a high pulse
      below = 1'b1;
      wait_hs(ok);
      en = 1'b0;
      step(1);
      @(negedge clk); #1;
      check(hs == 1'b0 && ls == 1'b0, "R9 disable clears", {hs, ls}, 0);
      pulses_before = hs_pulses;
      step(30);
      check(hs_pulses == pulses_before && hs == 1'b0, "R9 no pulse while off",
            hs_pulses - pulses_before, 0);
      en = 1'b1;
      step(1);
      #1 check(hs == 1'b0, "R9 gap cycle after enable", hs, 0);
      step(1);
      #1 check(hs == 1'b1, "R9 resume on second edge", hs, 1);
      below = 1'b0;
      step(40);

      // R9: disable while the rectifier conducts
      below = 1'b1;
      step(3);
      below = 1'b0;
      ok = 0;
      for (int i = 0; i < 60; i++) begin
         step(1);
         if (ls) begin ok = 1; break; end
      end
      en = 1'b0;
      step(1);
      #1 check(ls == 1'b0, "R9 disable drops ls", ls, 0);
      en = 1'b1;
      step(30);

      // R1: asynchronous reset mid-pulse
      below = 1'b1;
      wait_hs(ok);
      rst_n = 1'b0;
      #1 check(hs == 1'b0 && ls == 1'b0, "R1 async reset", {hs, ls}, 0);
      below = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(20);

      // R8: never both on
      check(overlap == 0, "R8 no overlap", overlap, 0);
      report();
   end

endmodule